// File: doc/BRIEF.md
# Tagged Variable-Length Integer Arithmetic Unit

This unit carries out integer arithmetic and bitwise logic on operands whose width and kind are described by a status byte attached to each value. It holds four 128-bit accumulators. Each one keeps a value together with the status byte that says how many of its bits are meaningful and whether the value is signed. A command names an operation, an accumulator and a memory operand with its own status byte. The unit then brings both operands to a common width and kind, computes the result, writes it back and reports it on a result port.

The front end hands commands over through a valid/ready handshake and can prepare the next command while the current one executes. Every command takes a fixed two cycles. The ready signal drops for the cycle after acceptance, and the result appears one cycle later as a single-cycle pulse. Floating or complex kinds, and opcodes the unit does not implement, raise a trap and leave the accumulator as it was.

Top module: `vla_unit`

## Requirements
- R1: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. In the cycle that follows, `busy` is high, `cmd_ready` is low and `res_valid` is low. In the cycle after that, `res_valid` is high for exactly one cycle and `busy` is low. With no command accepted, `res_valid` stays low.
- R2: A status byte holds the length code n in bits [3:0], meaning (n+1)*8 bits, and the kind in bits [7:4]: 0 for an unsigned logical value and 1 for a signed integer. A load (opcode 0) stores the operand fitted to its own status. Bits above the length become copies of the top valid bit for kind 1 and become zero for kind 0. The load returns that value and status.
- R3: For opcodes 2 to 6, the result length code is the larger of the two length codes. The result kind is the larger of the two kinds, so integer ranks above logical.
- R4: Add (opcode 2) and subtract (opcode 3, accumulator minus operand) widen integer operands by sign extension and logical operands by zero extension. The result is truncated to the result length and then fitted as in R2.
- R5: When the result kind is integer, add and subtract set `res_ovf` if the exact result does not fit in the result length as a signed number. In every other case `res_ovf` is low.
- R6: AND (opcode 4), OR (opcode 5) and XOR (opcode 6) act bitwise on the widened operands. The result is fitted to the result status.
- R7: Store (opcode 1) returns the accumulator's value and status on the result port and leaves the accumulator unchanged.
- R8: The unit traps when any of these holds: the opcode is 7; the operand kind is above 1 on any opcode except store; the accumulator kind is above 1 on opcodes 2 to 6. A trap sets `res_trap`, returns a zero value with the accumulator's status and no overflow, and leaves the accumulator unchanged.
- R9: After reset, every accumulator holds value 0 with status 8'h00, `cmd_ready` is high, and `busy` and `res_valid` are low.
- R10: A command writes only the accumulator it names. The other three keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_op | input | 3 | Opcode |
| cmd_acc | input | 2 | Accumulator index |
| cmd_data | input | 128 | Memory operand value |
| cmd_stat | input | 8 | Memory operand status byte |
| res_valid | output | 1 | Result pulse |
| res_data | output | 128 | Result value |
| res_stat | output | 8 | Result status byte |
| res_ovf | output | 1 | Signed overflow at result length |
| res_trap | output | 1 | Unimplemented operation or kind |
| busy | output | 1 | Command in execution |

## Verification
The bench targets the following corner cases:

- Operands of mixed length and mixed kind, such as an 8-bit negative integer added to a 16-bit integer, or a logical byte combined with a signed word. A design that extends the wrong way, or picks the smaller length, returns a wrong value or status.
- Overflow at 8 bits and at the full 128 bits, including the carry out of a 128-bit logical add. A detector that looks at a fixed width, or flags unsigned wrap, gives the wrong flag.
- Traps on a reserved opcode and on real and complex kinds, each followed by a store. A design that writes during a trap shows a changed accumulator on that store.
- Junk bits above the operand length. These expose a design that forgets to fit the value to its length.

// File: rtl/vla_pkg.sv
package vla_pkg;

    localparam int DATA_W    = 128;
    localparam int STEP_W    = 8;
    localparam int NUM_LEN   = DATA_W / STEP_W;
    localparam int LEN_W     = $clog2(NUM_LEN);
    localparam int XW        = DATA_W + 2;
    localparam int NUM_ACC   = 4;
    localparam int ACC_IDX_W = $clog2(NUM_ACC);

    localparam logic [3:0] K_LOGIC = 4'd0;
    localparam logic [3:0] K_INT   = 4'd1;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic [3:0]       kind;
        logic [LEN_W-1:0] len;
    } stat_t;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_ADD   = 3'd2,
        OP_SUB   = 3'd3,
        OP_AND   = 3'd4,
        OP_OR    = 3'd5,
        OP_XOR   = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    typedef struct packed {
        op_e                  op;
        logic [ACC_IDX_W-1:0] idx;
        word_t                data;
        stat_t                stat;
    } cmd_t;

    function automatic int unsigned len_bits(input logic [LEN_W-1:0] l);
        return (int'(l) + 1) * STEP_W;
    endfunction

    function automatic word_t len_mask(input logic [LEN_W-1:0] l);
        word_t m;
        m = '0;
        for (int i = 0; i < NUM_LEN; i++)
            if (i <= int'(l)) m[i*STEP_W +: STEP_W] = '1;
        return m;
    endfunction

    // Keep the valid bits and extend above them according to the kind.
    function automatic word_t fit(input word_t v, input stat_t s);
        word_t m;
        logic  top;
        m   = len_mask(s.len);
        top = v[len_bits(s.len) - 1];
        return (v & m) | ((s.kind == K_INT && top) ? ~m : '0);
    endfunction

    function automatic logic kind_ok(input logic [3:0] k);
        return (k == K_LOGIC) || (k == K_INT);
    endfunction

    function automatic stat_t wider(input stat_t a, input stat_t b);
        stat_t r;
        r.len  = (a.len  > b.len)  ? a.len  : b.len;
        r.kind = (a.kind > b.kind) ? a.kind : b.kind;
        return r;
    endfunction

endpackage

// File: rtl/vla_acc_bank.sv
module vla_acc_bank
    import vla_pkg::*;
#(
    parameter int N  = NUM_ACC,
    parameter int IW = ACC_IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  word_t         wval,
    input  stat_t         wstat,
    output word_t         rval,
    output stat_t         rstat
);
    word_t vals  [N];
    stat_t stats [N];

    for (genvar g = 0; g < N; g++) begin : g_acc
        word_t v_q;
        stat_t s_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= '0;
                s_q <= '0;
            end else if (we && idx == IW'(g)) begin
                v_q <= wval;
                s_q <= wstat;
            end
        end
        assign vals[g]  = v_q;
        assign stats[g] = s_q;
    end

    assign rval  = vals[idx];
    assign rstat = stats[idx];
endmodule

// File: rtl/vla_coerce.sv
module vla_coerce
    import vla_pkg::*;
(
    input  word_t a_val,
    input  stat_t a_stat,
    input  word_t b_val,
    input  stat_t b_stat,
    output word_t wa,
    output logic  xa,
    output word_t wb,
    output logic  xb,
    output stat_t rs,
    output logic  ok
);
    always_comb begin
        wa = fit(a_val, a_stat);
        wb = fit(b_val, b_stat);
        xa = (a_stat.kind == K_INT) & wa[DATA_W-1];
        xb = (b_stat.kind == K_INT) & wb[DATA_W-1];
        rs = wider(a_stat, b_stat);
        ok = kind_ok(a_stat.kind) & kind_ok(b_stat.kind);
    end
endmodule

// File: rtl/vla_alu.sv
module vla_alu
    import vla_pkg::*;
(
    input  op_e   op,
    input  word_t wa,
    input  logic  xa,
    input  word_t wb,
    input  logic  xb,
    input  stat_t rs,
    output word_t rv,
    output logic  ovf
);
    logic [XW-1:0]        ea, eb, sum;
    logic signed [XW-1:0] sh;
    word_t                raw;
    logic                 arith;

    always_comb begin
        ea    = {{2{xa}}, wa};
        eb    = {{2{xb}}, wb};
        sum   = (op == OP_SUB) ? (ea - eb) : (ea + eb);
        arith = (op == OP_ADD) || (op == OP_SUB);
        case (op)
            OP_AND:  raw = wa & wb;
            OP_OR:   raw = wa | wb;
            OP_XOR:  raw = wa ^ wb;
            OP_ADD,
            OP_SUB:  raw = sum[DATA_W-1:0];
            default: raw = wb;
        endcase
        rv  = fit(raw, rs);
        sh  = $signed(sum) >>> (len_bits(rs.len) - 1);
        ovf = arith && (rs.kind == K_INT) && (sh != '0) && (sh != '1);
    end
endmodule

// File: rtl/vla_unit.sv
module vla_unit
    import vla_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [2:0]           cmd_op,
    input  logic [ACC_IDX_W-1:0] cmd_acc,
    input  logic [DATA_W-1:0]    cmd_data,
    input  logic [7:0]           cmd_stat,
    output logic                 res_valid,
    output logic [DATA_W-1:0]    res_data,
    output logic [7:0]           res_stat,
    output logic                 res_ovf,
    output logic                 res_trap,
    output logic                 busy
);
    logic  busy_q;
    cmd_t  pend_q;
    logic  accept;

    word_t acc_v;
    stat_t acc_s;
    word_t wa, wb, alu_v, out_v;
    logic  xa, xb, ok, alu_ovf, out_ovf, trap, acc_we;
    stat_t rs, out_s;

    assign cmd_ready = !busy_q;
    assign busy      = busy_q;
    assign accept    = cmd_valid && cmd_ready;

    vla_acc_bank #(.N(NUM_ACC), .IW(ACC_IDX_W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (acc_we),
        .idx   (pend_q.idx),
        .wval  (out_v),
        .wstat (out_s),
        .rval  (acc_v),
        .rstat (acc_s)
    );

    vla_coerce u_coerce (
        .a_val  (acc_v),
        .a_stat (acc_s),
        .b_val  (pend_q.data),
        .b_stat (pend_q.stat),
        .wa     (wa),
        .xa     (xa),
        .wb     (wb),
        .xb     (xb),
        .rs     (rs),
        .ok     (ok)
    );

    vla_alu u_alu (
        .op  (pend_q.op),
        .wa  (wa),
        .xa  (xa),
        .wb  (wb),
        .xb  (xb),
        .rs  (rs),
        .rv  (alu_v),
        .ovf (alu_ovf)
    );

    always_comb begin
        case (pend_q.op)
            OP_RSVD:  trap = 1'b1;
            OP_LOAD:  trap = !kind_ok(pend_q.stat.kind);
            OP_STORE: trap = 1'b0;
            default:  trap = !ok;
        endcase

        out_ovf = 1'b0;
        if (trap) begin
            out_v = '0;
            out_s = acc_s;
        end else if (pend_q.op == OP_LOAD) begin
            out_v = wb;
            out_s = pend_q.stat;
        end else if (pend_q.op == OP_STORE) begin
            out_v = acc_v;
            out_s = acc_s;
        end else begin
            out_v   = alu_v;
            out_s   = rs;
            out_ovf = alu_ovf;
        end

        acc_we = busy_q && !trap && (pend_q.op != OP_STORE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            pend_q    <= '0;
            res_valid <= 1'b0;
            res_data  <= '0;
            res_stat  <= '0;
            res_ovf   <= 1'b0;
            res_trap  <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                pend_q <= '{op: op_e'(cmd_op), idx: cmd_acc,
                           data: cmd_data, stat: stat_t'(cmd_stat)};
            end else if (busy_q) begin
                busy_q    <= 1'b0;
                res_valid <= 1'b1;
                res_data  <= out_v;
                res_stat  <= out_s;
                res_ovf   <= out_ovf;
                res_trap  <= trap;
            end
        end
    end
endmodule

// File: rtl/vla_unit_chk.sv
module vla_unit_chk
    import vla_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [2:0]        cmd_op,
    input logic [7:0]        cmd_stat,
    input logic              busy,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic [7:0]        res_stat,
    input logic              res_ovf,
    input logic              res_trap
);
    a_r1_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> (busy && !res_valid));

    a_r1_result_follows: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> ##1 (res_valid && !busy));

    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    a_r5_ovf_integer: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_ovf) |-> (res_stat[7:4] == K_INT && !res_trap));

    a_r8_trap_clean: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_trap) |-> (!res_ovf && res_data == '0));

    a_r3_len_max: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_trap && $past(cmd_op, 2) >= 3'd2 && $past(cmd_op, 2) <= 3'd6)
        |-> (res_stat[3:0] >= $past(cmd_stat[3:0], 2)));

    a_r2_logic_upper: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_trap && res_stat[7:4] == K_LOGIC)
        |-> ((res_data & ~len_mask(res_stat[3:0])) == '0));
endmodule

bind vla_unit vla_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_stat  (cmd_stat),
    .busy      (busy),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_stat  (res_stat),
    .res_ovf   (res_ovf),
    .res_trap  (res_trap)
);

// File: tb/tb_vla_unit.sv
`timescale 1ns/1ps
module tb_vla_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [2:0]   cmd_op = '0;
    logic [1:0]   cmd_acc = '0;
    logic [127:0] cmd_data = '0;
    logic [7:0]   cmd_stat = '0;
    logic         res_valid;
    logic [127:0] res_data;
    logic [7:0]   res_stat;
    logic         res_ovf, res_trap, busy;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [127:0] ref_val  [4];
    logic [7:0]   ref_stat [4];

    always #2 clk = ~clk;

    vla_unit dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_acc(cmd_acc), .cmd_data(cmd_data), .cmd_stat(cmd_stat),
        .res_valid(res_valid), .res_data(res_data), .res_stat(res_stat),
        .res_ovf(res_ovf), .res_trap(res_trap), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] bfit(input logic [127:0] v, input logic [7:0] st);
        int w;
        logic [127:0] r;
        w = (int'(st[3:0]) + 1) * 8;
        r = v;
        for (int i = w; i < 128; i++) r[i] = (st[7:4] == 4'd1) ? v[w-1] : 1'b0;
        return r;
    endfunction

    function automatic logic [129:0] ext(input logic [127:0] v, input logic [7:0] st);
        return {(st[7:4] == 4'd1) ? {2{v[127]}} : 2'b00, v};
    endfunction

    function automatic bit bovf(input logic [129:0] s, input int w);
        for (int i = w; i < 130; i++) if (s[i] != s[w-1]) return 1;
        return 0;
    endfunction

    task automatic run(input logic [2:0] op, input logic [1:0] idx,
                       input logic [127:0] data, input logic [7:0] st, input string tag);
        logic [127:0] a, b, ev;
        logic [7:0]   as, es;
        logic [129:0] s;
        bit           eovf, etrap;
        a  = ref_val[idx];
        as = ref_stat[idx];
        b  = bfit(data, st);
        es = {(as[7:4] > st[7:4]) ? as[7:4] : st[7:4], (as[3:0] > st[3:0]) ? as[3:0] : st[3:0]};
        etrap = (op == 3'd7) || (op != 3'd1 && st[7:4] > 4'd1) || (op >= 3'd2 && as[7:4] > 4'd1);
        eovf  = 0;
        ev    = '0;
        s     = '0;
        if (etrap) begin
            es = as;
        end else if (op == 3'd0) begin
            ev = b; es = st;
            ref_val[idx] = ev; ref_stat[idx] = es;
        end else if (op == 3'd1) begin
            ev = a; es = as;
        end else begin
            case (op)
                3'd2: s = ext(a, as) + ext(b, st);
                3'd3: s = ext(a, as) - ext(b, st);
                3'd4: s = {2'b00, a & b};
                3'd5: s = {2'b00, a | b};
                default: s = {2'b00, a ^ b};
            endcase
            ev = bfit(s[127:0], es);
            if (op <= 3'd3 && es[7:4] == 4'd1) eovf = bovf(s, (int'(es[3:0]) + 1) * 8);
            ref_val[idx] = ev; ref_stat[idx] = es;
        end

        @(negedge clk);
        chk(cmd_ready === 1'b1, "R1 ready before command", 128'(cmd_ready), 128'd1);
        cmd_op = op; cmd_acc = idx; cmd_data = data; cmd_stat = st; cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy === 1'b1 && cmd_ready === 1'b0 && res_valid === 1'b0,
            "R1 busy cycle", {125'd0, busy, cmd_ready, res_valid}, 128'b100);
        @(negedge clk);
        chk(res_valid === 1'b1 && busy === 1'b0, "R1 result pulse",
            {126'd0, res_valid, busy}, 128'b10);
        chk(res_data === ev, {tag, " value"}, res_data, ev);
        chk(res_stat === es, {tag, " status"}, 128'(res_stat), 128'(es));
        chk(res_ovf === eovf, "R5 overflow flag", 128'(res_ovf), 128'(eovf));
        chk(res_trap === etrap, "R8 trap flag", 128'(res_trap), 128'(etrap));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin ref_val[i] = '0; ref_stat[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state at the ports
        chk(cmd_ready === 1'b1 && busy === 1'b0 && res_valid === 1'b0, "R9 reset outputs",
            {125'd0, cmd_ready, busy, res_valid}, 128'b100);
        repeat (3) @(negedge clk);
        chk(res_valid === 1'b0, "R1 idle no result", 128'(res_valid), 128'd0);
        for (int i = 0; i < 4; i++) run(3'd1, 2'(i), '0, 8'h00, "R9 reset accumulator");

        // R2: loads with junk above the length
        run(3'd0, 2'd0, 128'hDEAD_BEEF_0080, 8'h10, "R2 load int8");
        run(3'd0, 2'd1, 128'h1234_FFFF_ABCD, 8'h01, "R2 load logic16");
        run(3'd1, 2'd0, '0, 8'h00, "R7 store acc0");
        run(3'd1, 2'd0, 128'h55, 8'h00, "R7 store repeat");

        // R3, R4: mixed lengths
        run(3'd2, 2'd0, 128'hFF00_0100, 8'h11, "R4 add int8 to int16");
        run(3'd3, 2'd0, 128'h7, 8'h10, "R4 sub int16 minus int8");
        run(3'd2, 2'd1, 128'h1, 8'h10, "R3 logic16 plus int8");

        // R5: overflow corners
        run(3'd0, 2'd2, 128'h7F, 8'h10, "R2 load int8 max");
        run(3'd2, 2'd2, 128'h1, 8'h10, "R5 add overflow int8");
        run(3'd0, 2'd3, 128'h80, 8'h10, "R2 load int8 min");
        run(3'd3, 2'd3, 128'h1, 8'h10, "R5 sub overflow int8");
        run(3'd0, 2'd3, 128'hFF, 8'h00, "R2 load logic8");
        run(3'd2, 2'd3, 128'h1, 8'h10, "R4 logic8 plus int8");
        run(3'd0, 2'd2, {1'b0, {127{1'b1}}}, 8'h1F, "R2 load int128 max");
        run(3'd2, 2'd2, 128'h1, 8'h1F, "R5 add overflow int128");
        run(3'd0, 2'd3, {128{1'b1}}, 8'h0F, "R2 load logic128");
        run(3'd2, 2'd3, 128'h1, 8'h0F, "R5 logic128 wrap no flag");
        run(3'd2, 2'd3, {1'b0, {127{1'b1}}}, 8'h1F, "R5 logic128 plus int128");

        // R6: logic operations
        run(3'd4, 2'd1, 128'h0FF0, 8'h01, "R6 and");
        run(3'd5, 2'd1, 128'hF000_0000, 8'h03, "R6 or widening");
        run(3'd6, 2'd1, {128{1'b1}}, 8'h00, "R6 xor logic8");
        run(3'd6, 2'd0, 128'hFF, 8'h00, "R6 xor int16 with logic8");

        // R8: traps leave the accumulator alone
        run(3'd7, 2'd0, 128'h1234, 8'h11, "R8 reserved opcode");
        run(3'd2, 2'd0, 128'h5, 8'h20, "R8 real kind");
        run(3'd0, 2'd1, 128'h5, 8'h35, "R8 complex load");
        run(3'd1, 2'd0, '0, 8'h00, "R8 acc0 unchanged");
        run(3'd1, 2'd1, '0, 8'h00, "R8 acc1 unchanged");

        // R10: other accumulators untouched
        run(3'd0, 2'd2, 128'h42, 8'h13, "R10 write acc2");
        run(3'd1, 2'd3, '0, 8'h00, "R10 acc3 intact");
        run(3'd1, 2'd0, '0, 8'h00, "R10 acc0 intact");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule